// File: doc/BRIEF.md
# Convergence Test Cursor Injector

This block sits between a dynamic convergence correction generator and the six correction DACs of a display: one horizontal and one vertical correction for each of red, green and blue. Normally it forwards the correction samples unchanged, one clock late. When the cursor feature is switched on and the current video line is a gain-measuring line, it replaces every correction sample with a programmed per-channel, per-axis cursor constant. This draws a test cursor that lines up with a matching video pattern.

The sign of the substituted constants follows a rule that depends on the cursor direction. A vertical cursor is positive on the first measuring line and then alternates from line to line. A horizontal cursor is negated on every measuring line. Separate horizontal and vertical polarity bits invert the result on top of that rule. The block also carries a shared coarse gain word, three per-channel fine gain words and two insertion-mode status bits to the gain path. All control words and constants are captured at line start, so no setting can change in the middle of a line.

Top module: `cvg_cursor_inject`

## Requirements
- R1: While the captured cursor enable is 0, or the captured line is not a measuring line, `dacH`/`dacV` equal `dynH`/`dynV` from the previous clock, on every line.
- R2: While the captured enable is 1 and the captured line is a measuring line, each lane of `dacH`/`dacV` carries that lane's captured constant from `curH`/`curV`, with lane 0 = red (bits 7:0), lane 1 = green, lane 2 = blue, and possibly negated.
- R3: With `cursorVert`=1 (vertical), the first measuring line after the measuring flag rises is positive and each later measuring line flips the sign.
- R4: With `cursorVert`=0 (horizontal), the substituted values are negated on every measuring line.
- R5: `polH`=1 inverts the sign of the horizontal lanes only, and `polV`=1 inverts the sign of the vertical lanes only, on top of R3/R4.
- R6: Values are two's complement. Negating 0x80 gives 0x7F, and any other value x gives -x.
- R7: Mode bits, cursor constants, gain words and the measuring flag are captured only on a clock with `lineStart`=1. Changes between line starts have no effect on the outputs.
- R8: `coarseOut` and `fineOut` show the `coarseGain` and `fineGain` captured at the last line start.
- R9: `insTypeOut`/`insDirOut` show the `insType`/`insDir` captured at the last line start and do not affect the DAC values.
- R10: While `rstN`=0 all outputs are 0 and the line parity is positive.
- R11: A change on `dynH`/`dynV` reaches the DAC outputs after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-clock strobe at the start of each video line |
| measLine | input | 1 | High when the starting line is a gain-measuring line |
| cursorEn | input | 1 | Cursor substitution enable |
| cursorVert | input | 1 | Cursor direction: 0 horizontal, 1 vertical |
| polH | input | 1 | Invert horizontal substituted values |
| polV | input | 1 | Invert vertical substituted values |
| insType | input | 1 | Insertion type status: 0 field offset cancel, 1 gain compensation |
| insDir | input | 1 | Insertion direction status: 0 vertical, 1 horizontal |
| dynH | input | 3*DATA_W | Dynamic horizontal corrections, red in the low lane |
| dynV | input | 3*DATA_W | Dynamic vertical corrections, red in the low lane |
| curH | input | 3*DATA_W | Horizontal cursor constants per channel |
| curV | input | 3*DATA_W | Vertical cursor constants per channel |
| coarseGain | input | GAIN_W | Shared coarse gain word |
| fineGain | input | 3*GAIN_W | Per-channel fine gain words |
| dacH | output | 3*DATA_W | Horizontal DAC samples |
| dacV | output | 3*DATA_W | Vertical DAC samples |
| coarseOut | output | GAIN_W | Captured coarse gain |
| fineOut | output | 3*GAIN_W | Captured fine gains |
| insTypeOut | output | 1 | Captured insertion type |
| insDirOut | output | 1 | Captured insertion direction |

## Verification
The line parity cannot be seen or set from the ports. It shows only through the sign of substituted values, and only after a run of measuring lines that began on a rising measuring flag. The stimulus therefore walks a scripted field. It has a non-measuring line, then several measuring lines in vertical mode, then a gap, then horizontal lines, a disabled measuring line and a second rise of the flag. This covers a parity restart as well as continued alternation, and the polarity bits are flipped partway through. The constants include 0x80 so that saturation shows on the green horizontal lane whenever that lane is negated.

// File: rtl/cvg_cursor_pkg.sv
package cvg_cursor_pkg;
  localparam int NUM_CH = 3;

  typedef struct packed {
    logic load;   // capture constants this clock
    logic subst;  // replace dynamic samples with constants
    logic negH;   // negate horizontal substitutes
    logic negV;   // negate vertical substitutes
  } ctrlStrobe_t;
endpackage

// File: rtl/cvg_cursor_ctrl.sv
module cvg_cursor_ctrl
  import cvg_cursor_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStart,
  input  logic        measLine,
  input  logic        cursorEn,
  input  logic        cursorVert,
  input  logic        polH,
  input  logic        polV,
  input  logic        insType,
  input  logic        insDir,
  output ctrlStrobe_t strb,
  output logic        measQ,
  output logic        vertQ,
  output logic        polHQ,
  output logic        insTypeQ,
  output logic        insDirQ
);
  logic enQ;
  logic polVQ;
  logic parityQ;
  logic firstLine;
  logic lineFlip;

  // The measuring flag rising at a line start marks the first measuring line.
  assign firstLine = measLine && !measQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      vertQ    <= 1'b0;
      polHQ    <= 1'b0;
      polVQ    <= 1'b0;
      insTypeQ <= 1'b0;
      insDirQ  <= 1'b0;
      measQ    <= 1'b0;
      parityQ  <= 1'b0;
    end else if (lineStart) begin
      enQ      <= cursorEn;
      vertQ    <= cursorVert;
      polHQ    <= polH;
      polVQ    <= polV;
      insTypeQ <= insType;
      insDirQ  <= insDir;
      measQ    <= measLine;
      parityQ  <= firstLine ? 1'b0 : ~parityQ;
    end
  end

  // Vertical cursor alternates with parity; horizontal is negated on every line.
  assign lineFlip   = vertQ ? parityQ : 1'b1;

  assign strb.load  = lineStart;
  assign strb.subst = enQ && measQ;
  assign strb.negH  = lineFlip ^ polHQ;
  assign strb.negV  = lineFlip ^ polVQ;
endmodule

// File: rtl/cvg_cursor_dp.sv
module cvg_cursor_dp
  import cvg_cursor_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GAIN_W = 8,
  parameter int LANES  = NUM_CH
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strb,
  input  logic [LANES*DATA_W-1:0]   dynH,
  input  logic [LANES*DATA_W-1:0]   dynV,
  input  logic [LANES*DATA_W-1:0]   curH,
  input  logic [LANES*DATA_W-1:0]   curV,
  input  logic [GAIN_W-1:0]         coarseGain,
  input  logic [LANES*GAIN_W-1:0]   fineGain,
  output logic [LANES*DATA_W-1:0]   dacH,
  output logic [LANES*DATA_W-1:0]   dacV,
  output logic [GAIN_W-1:0]         coarseOut,
  output logic [LANES*GAIN_W-1:0]   fineOut
);
  localparam int VEC_W = LANES * DATA_W;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic [VEC_W-1:0] curHQ;
  logic [VEC_W-1:0] curVQ;
  logic [VEC_W-1:0] dacHQ;
  logic [VEC_W-1:0] dacVQ;
  logic [GAIN_W-1:0] coarseQ;
  logic [LANES*GAIN_W-1:0] fineQ;
  logic [DATA_W-1:0] nextH [LANES];
  logic [DATA_W-1:0] nextV [LANES];

  function automatic logic [DATA_W-1:0] satNeg(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    if (v == MOST_NEG) r = MOST_POS;
    else               r = ~v + 1'b1;
    return r;
  endfunction

  // Shadow copies of constants and gain words, taken at line start only.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curHQ   <= '0;
      curVQ   <= '0;
      coarseQ <= '0;
      fineQ   <= '0;
    end else if (strb.load) begin
      curHQ   <= curH;
      curVQ   <= curV;
      coarseQ <= coarseGain;
      fineQ   <= fineGain;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] cH;
    logic [DATA_W-1:0] cV;
    logic [DATA_W-1:0] sH;
    logic [DATA_W-1:0] sV;
    assign cH = curHQ[g*DATA_W +: DATA_W];
    assign cV = curVQ[g*DATA_W +: DATA_W];
    assign sH = strb.negH ? satNeg(cH) : cH;
    assign sV = strb.negV ? satNeg(cV) : cV;
    assign nextH[g] = strb.subst ? sH : dynH[g*DATA_W +: DATA_W];
    assign nextV[g] = strb.subst ? sV : dynV[g*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacHQ <= '0;
      dacVQ <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        dacHQ[i*DATA_W +: DATA_W] <= nextH[i];
        dacVQ[i*DATA_W +: DATA_W] <= nextV[i];
      end
    end
  end

  assign dacH      = dacHQ;
  assign dacV      = dacVQ;
  assign coarseOut = coarseQ;
  assign fineOut   = fineQ;
endmodule

// File: rtl/cvg_cursor_inject.sv
module cvg_cursor_inject
  import cvg_cursor_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GAIN_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lineStart,
  input  logic                     measLine,
  input  logic                     cursorEn,
  input  logic                     cursorVert,
  input  logic                     polH,
  input  logic                     polV,
  input  logic                     insType,
  input  logic                     insDir,
  input  logic [3*DATA_W-1:0]      dynH,
  input  logic [3*DATA_W-1:0]      dynV,
  input  logic [3*DATA_W-1:0]      curH,
  input  logic [3*DATA_W-1:0]      curV,
  input  logic [GAIN_W-1:0]        coarseGain,
  input  logic [3*GAIN_W-1:0]      fineGain,
  output logic [3*DATA_W-1:0]      dacH,
  output logic [3*DATA_W-1:0]      dacV,
  output logic [GAIN_W-1:0]        coarseOut,
  output logic [3*GAIN_W-1:0]      fineOut,
  output logic                     insTypeOut,
  output logic                     insDirOut
);
  ctrlStrobe_t strb;
  logic measQ;
  logic vertQ;
  logic polHQ;

  cvg_cursor_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .measLine  (measLine),
    .cursorEn  (cursorEn),
    .cursorVert(cursorVert),
    .polH      (polH),
    .polV      (polV),
    .insType   (insType),
    .insDir    (insDir),
    .strb      (strb),
    .measQ     (measQ),
    .vertQ     (vertQ),
    .polHQ     (polHQ),
    .insTypeQ  (insTypeOut),
    .insDirQ   (insDirOut)
  );

  cvg_cursor_dp #(
    .DATA_W(DATA_W),
    .GAIN_W(GAIN_W),
    .LANES (NUM_CH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dynH      (dynH),
    .dynV      (dynV),
    .curH      (curH),
    .curV      (curV),
    .coarseGain(coarseGain),
    .fineGain  (fineGain),
    .dacH      (dacH),
    .dacV      (dacV),
    .coarseOut (coarseOut),
    .fineOut   (fineOut)
  );
endmodule

// File: rtl/cvg_cursor_inject_chk.sv
module cvg_cursor_inject_chk #(
  parameter int DATA_W = 8,
  parameter int GAIN_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                lineStart,
  input logic                measLine,
  input logic                cursorEn,
  input logic                cursorVert,
  input logic                polH,
  input logic [3*DATA_W-1:0] dynH,
  input logic [3*DATA_W-1:0] dynV,
  input logic [3*DATA_W-1:0] curH,
  input logic [3*DATA_W-1:0] dacH,
  input logic [3*DATA_W-1:0] dacV,
  input logic [GAIN_W-1:0]   coarseOut,
  input logic [3*GAIN_W-1:0] fineOut,
  input logic                insTypeOut,
  input logic                insDirOut,
  input logic                strbSubst,
  input logic                strbNegH,
  input logic                measQ,
  input logic                vertQ,
  input logic                polHQ
);
  p_pass_through_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strbSubst |=> (dacH == $past(dynH)) && (dacV == $past(dynV)));

  p_vert_first_positive_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && measLine && !measQ && cursorEn && cursorVert && !polH)
      |=> ##1 ($past(lineStart) || (dacH == $past(curH, 2))));

  p_vert_alternates_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && measLine && measQ && vertQ && cursorVert && (polH == polHQ))
      |=> (strbNegH != $past(strbNegH)));

  p_horiz_negated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && !cursorVert) |=> (strbNegH == !$past(polH)));

  p_held_midline_r7: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> $stable(coarseOut) && $stable(fineOut)
                   && $stable(insTypeOut) && $stable(insDirOut));
endmodule

bind cvg_cursor_inject cvg_cursor_inject_chk #(
  .DATA_W(DATA_W),
  .GAIN_W(GAIN_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lineStart (lineStart),
  .measLine  (measLine),
  .cursorEn  (cursorEn),
  .cursorVert(cursorVert),
  .polH      (polH),
  .dynH      (dynH),
  .dynV      (dynV),
  .curH      (curH),
  .dacH      (dacH),
  .dacV      (dacV),
  .coarseOut (coarseOut),
  .fineOut   (fineOut),
  .insTypeOut(insTypeOut),
  .insDirOut (insDirOut),
  .strbSubst (strb.subst),
  .strbNegH  (strb.negH),
  .measQ     (measQ),
  .vertQ     (vertQ),
  .polHQ     (polHQ)
);

// File: tb/cvg_cursor_inject_test.sv
`timescale 1ns/1ps
module cvg_cursor_inject_test;
  localparam int DW = 8;
  localparam int GW = 8;

  logic clk = 1'b0;
  logic rstN;
  logic lineStart, measLine, cursorEn, cursorVert, polH, polV, insType, insDir;
  logic [3*DW-1:0] dynH, dynV, curH, curV, dacH, dacV;
  logic [GW-1:0] coarseGain, coarseOut;
  logic [3*GW-1:0] fineGain, fineOut;
  logic insTypeOut, insDirOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  cvg_cursor_inject #(.DATA_W(DW), .GAIN_W(GW)) uut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .measLine(measLine),
    .cursorEn(cursorEn), .cursorVert(cursorVert), .polH(polH), .polV(polV),
    .insType(insType), .insDir(insDir), .dynH(dynH), .dynV(dynV),
    .curH(curH), .curV(curV), .coarseGain(coarseGain), .fineGain(fineGain),
    .dacH(dacH), .dacV(dacV), .coarseOut(coarseOut), .fineOut(fineOut),
    .insTypeOut(insTypeOut), .insDirOut(insDirOut)
  );

  // Line script: {meas, en, vert, polH, polV, expSubst, expNegH, expNegV}
  localparam logic [7:0] VEC [13] = '{
    8'b0_1_1_0_0_0_0_0,  // not measuring: pass through (R1)
    8'b1_1_1_0_0_1_0_0,  // flag rises, vertical: positive (R3)
    8'b1_1_1_0_0_1_1_1,  // next line negated (R3)
    8'b1_1_1_0_0_1_0_0,  // back to positive (R3)
    8'b1_1_1_1_0_1_0_1,  // parity odd, polH inverts horizontal only (R5)
    8'b0_1_1_0_0_0_0_0,  // gap
    8'b1_1_0_0_0_1_1_1,  // horizontal: negated (R4)
    8'b1_1_0_0_0_1_1_1,  // horizontal: still negated (R4)
    8'b1_1_0_0_1_1_1_0,  // polV inverts vertical only (R5)
    8'b1_0_0_0_0_0_0_0,  // disabled on measuring line (R1)
    8'b0_1_1_0_0_0_0_0,  // gap
    8'b1_1_1_1_1_1_1_1,  // rise again, both polarities (R3, R5)
    8'b1_1_1_1_1_1_0_0   // alternates with both polarities
  };

  localparam logic [3*DW-1:0] CUR_H = {8'h7F, 8'h80, 8'h05};
  localparam logic [3*DW-1:0] CUR_V = {8'hFF, 8'h01, 8'h20};

  function automatic logic [DW-1:0] negSat(input logic [DW-1:0] v);
    if (v == 8'h80) return 8'h7F;
    return 8'(0 - int'(v));
  endfunction

  function automatic logic [3*DW-1:0] expVec(input logic sub, input logic neg,
                                             input logic [3*DW-1:0] c,
                                             input logic [3*DW-1:0] d);
    logic [3*DW-1:0] r;
    for (int k = 0; k < 3; k++)
      r[k*DW +: DW] = !sub ? d[k*DW +: DW] : (neg ? negSat(c[k*DW +: DW]) : c[k*DW +: DW]);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a line start at a falling edge, then sample one edge after capture.
  task automatic runLine(input logic m, input logic e, input logic v, input logic ph,
                         input logic pv, input logic it, input logic id,
                         input logic [3*DW-1:0] dh, input logic [3*DW-1:0] dv,
                         input logic [GW-1:0] cg, input logic [3*GW-1:0] fg);
    lineStart = 1'b1; measLine = m; cursorEn = e; cursorVert = v;
    polH = ph; polV = pv; insType = it; insDir = id;
    dynH = dh; dynV = dv; coarseGain = cg; fineGain = fg;
    @(posedge clk); @(negedge clk);
    lineStart = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; lineStart = 1'b1; measLine = 1'b1; cursorEn = 1'b1;
    cursorVert = 1'b1; polH = 1'b1; polV = 1'b1; insType = 1'b1; insDir = 1'b1;
    dynH = '1; dynV = '1; curH = CUR_H; curV = CUR_V;
    coarseGain = 8'hEE; fineGain = 24'hABCDEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset holds everything at zero
    check("R10 dacH", dacH, 0);
    check("R10 dacV", dacV, 0);
    check("R10 gain", {coarseOut, fineOut}, 0);
    check("R10 status", {insTypeOut, insDirOut}, 0);
    lineStart = 1'b0;
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);

    for (int i = 0; i < 13; i++) begin
      logic [7:0] vv;
      logic [3*DW-1:0] dh, dv;
      vv = VEC[i];
      dh = {8'(8'h40 + i), 8'(8'h30 + i), 8'(8'h20 + i)};
      dv = {8'(8'hC0 - i), 8'(8'hB0 - i), 8'(8'hA0 - i)};
      runLine(vv[7], vv[6], vv[5], vv[4], vv[3], i[0], i[1], dh, dv,
              8'(8'h10 + i), {8'(8'h60 + i), 8'(8'h50 + i), 8'(8'h70 + i)});
      // R2, R3, R4, R5, R6 via expected sign; R1 when not substituted
      check($sformatf("R2 line %0d dacH", i), dacH, expVec(vv[2], vv[1], CUR_H, dh));
      check($sformatf("R2 line %0d dacV", i), dacV, expVec(vv[2], vv[0], CUR_V, dv));
      check($sformatf("R8 line %0d coarse", i), coarseOut, 8'(8'h10 + i));
      check($sformatf("R8 line %0d fine", i), fineOut,
            {8'(8'h60 + i), 8'(8'h50 + i), 8'(8'h70 + i)});
      check($sformatf("R9 line %0d status", i), {insTypeOut, insDirOut}, {i[0], i[1]});
    end

    // R6: green horizontal 0x80 negated saturates to 0x7F (horizontal line)
    runLine(1, 1, 0, 0, 0, 0, 0, '0, '0, 8'h01, 24'h010203);
    check("R6 green saturation", dacH[15:8], 8'h7F);
    check("R4 red negated", dacH[7:0], 8'hFB);

    // R7: mid-line changes to mode, constants and gain have no effect
    cursorEn = 1'b0; cursorVert = 1'b1; polH = 1'b1; measLine = 1'b0;
    curH = 24'h111111; coarseGain = 8'h99; insType = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 dacH held", dacH, {8'h81, 8'h7F, 8'hFB});
    check("R7 gain held", coarseOut, 8'h01);
    check("R7 status held", insTypeOut, 1'b0);
    curH = CUR_H;

    // R1 / R11: disabled line passes dynamic samples with one clock latency
    runLine(1, 0, 1, 0, 0, 0, 0, 24'h123456, 24'h654321, 8'h02, 24'h0);
    check("R1 pass H", dacH, 24'h123456);
    dynH = 24'hA5A55A;
    #1;
    check("R11 not before edge", dacH, 24'h123456);
    @(posedge clk); @(negedge clk);
    check("R11 one edge later", dacH, 24'hA5A55A);
    check("R1 pass V", dacV, 24'h654321);

    // R10: reset mid-run clears outputs and restarts parity
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 mid-run reset", {dacH, dacV}, 0);
    rstN = 1'b1;
    runLine(1, 1, 1, 0, 0, 0, 0, '0, '0, 8'h00, 24'h0);
    check("R3 positive after reset", dacV, CUR_V);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule